// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The block collects eight interrupt inputs, latches each on its rising edge, ranks them by fixed priority (input 0 wins) and raises one request line toward a processor. It has an 8-bit register port. A one-bit address selects either the command port (`addr` = 0) or the data port (`addr` = 1). Inside are a request register, an in-service register and a mask register. It also holds a vector base and a cascade configuration word, both loaded during initialization.

Software brings the controller up with a short initialization sequence on the two ports. It acknowledges interrupts by writing a poll command and then reading the command port. It retires them with a non-specific end-of-interrupt. No hardware acknowledge cycle is used. An interrupt whose input dropped before acknowledge shows up as input 7 with in-service bit 7 clear, and software treats that as spurious. Read data is combinational and is valid during the cycle in which `rdEn` is high. All register updates take effect on the rising clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register is 0xFF, the request and in-service registers are zero, `intOut` is low, and a command-port read returns the request register.
- R2: A command-port write with bit 4 set starts initialization, and the next data-port writes are then taken in order. The first is the vector base. The cascade word follows only when bit 1 of the first word was clear. The mode word follows only when bit 0 of the first word was set. None of these writes changes the mask.
- R3: Outside initialization, a data-port write loads the mask register and a data-port read returns it. A set mask bit keeps that input from driving `intOut`, although the input is still recorded in the request register.
- R4: A rising edge on an input sets its request bit. The bit clears when the input falls before acknowledge.
- R5: When several unmasked requests are pending, the lowest-numbered input wins.
- R6: After a command-port write of 0x0C, the next command-port read returns {bit 7 = 1, bits 6:3 = 0, bits 2:0 = winning input}. In the same cycle it sets that input's in-service bit and clears its request bit. Later reads return the selected register again.
- R7: A poll with nothing pending returns 0x07 and leaves the in-service register unchanged, so in-service bit 7 reads clear.
- R8: A command-port write of 0x0B selects the in-service register for command-port reads, and a write of 0x0A selects the request register. The selection persists across reads.
- R9: A command-port write of 0x20 clears only the highest-priority set bit of the in-service register.
- R10: `intOut` is high exactly when an unmasked request has a lower input number than every set in-service bit. An input in service therefore blocks inputs of equal or lower priority.
- R11: A rising edge on an input whose in-service bit is set is ignored.
- R12: `vecOut` carries the vector base in bits 7:3 and the winning pending input number in bits 2:0, or 7 when nothing is pending.
- R13: Starting initialization clears the request and in-service registers, points reads back at the request register and cancels a pending poll. The mask is kept.
- R14: `cascOut` holds the last cascade word written during initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irqIn | input | 8 | Interrupt inputs, input 0 highest priority |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector base combined with winning input number |
| cascOut | output | 8 | Cascade configuration word |

## Verification
A wrong request register shows up in the same cycle on `intOut` and on the low bits of `vecOut`, and on the next command-port read. An in-service bit that is wrong or stuck shows up as a poll result that cannot occur, as a request line that stays blocked after end-of-interrupt, or as a stale value on the in-service readback. Every such fault is visible within one or two register accesses after the stimulus that caused it. A broken initialization counter misroutes the next data-port write, and the mask or the cascade readback shows this right away.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef struct packed {
    logic initClr;
    logic loadMask;
    logic loadVec;
    logic loadCasc;
    logic eoi;
    logic pollAck;
  } picStrobes_t;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_VEC,
    ST_CASC,
    ST_MODE
  } initState_t;

endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] vecIn,
  output logic              anySet,
  output logic [IDX_W-1:0]  topIdx,
  output logic [NUM_IN-1:0] topOh
);

  always_comb begin
    anySet = 1'b0;
    topIdx = IDX_W'(NUM_IN - 1);
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        anySet = 1'b1;
        topIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    topOh = '0;
    if (anySet) topOh[topIdx] = 1'b1;
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_IN),
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [DATA_W-1:0] wrData,
  input  picStrobes_t       strobes,
  output logic [NUM_IN-1:0] irr,
  output logic [NUM_IN-1:0] isr,
  output logic [NUM_IN-1:0] imr,
  output logic              pendValid,
  output logic [IDX_W-1:0]  pendIdx,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] cascOut
);

  logic [NUM_IN-1:0] irqPrev;
  logic [NUM_IN-1:0] rising;
  logic [NUM_IN-1:0] reqVec;
  logic              reqAny;
  logic [IDX_W-1:0]  reqIdx;
  logic [NUM_IN-1:0] reqOh;
  logic              isrAny;
  logic [IDX_W-1:0]  isrIdx;
  logic [NUM_IN-1:0] isrOh;
  logic [BASE_W-1:0] vecBase;
  logic [NUM_IN-1:0] irrNext;
  logic [NUM_IN-1:0] isrNext;

  assign reqVec = irr & ~imr;

  pic_prio_enc #(.NUM_IN(NUM_IN)) i_reqEnc (
    .vecIn (reqVec),
    .anySet(reqAny),
    .topIdx(reqIdx),
    .topOh (reqOh)
  );

  pic_prio_enc #(.NUM_IN(NUM_IN)) i_isrEnc (
    .vecIn (isr),
    .anySet(isrAny),
    .topIdx(isrIdx),
    .topOh (isrOh)
  );

  assign pendValid = reqAny && (!isrAny || (reqIdx < isrIdx));
  assign pendIdx   = pendValid ? reqIdx : IDX_W'(NUM_IN - 1);
  assign vecOut    = {vecBase, pendIdx};

  assign rising = irqIn & ~irqPrev & ~isr;

  always_comb begin
    irrNext = (irr | rising) & irqIn;
    if (strobes.pollAck) irrNext = irrNext & ~reqOh;
    if (strobes.initClr) irrNext = '0;
  end

  always_comb begin
    isrNext = isr;
    if (strobes.eoi) isrNext = isrNext & ~isrOh;
    if (strobes.pollAck) isrNext = isrNext | reqOh;
    if (strobes.initClr) isrNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqPrev <= '0;
      irr     <= '0;
      isr     <= '0;
      imr     <= '1;
      vecBase <= '0;
      cascOut <= '0;
    end else begin
      irqPrev <= irqIn;
      irr     <= irrNext;
      isr     <= isrNext;
      if (strobes.loadMask) imr <= wrData[NUM_IN-1:0];
      if (strobes.loadVec) vecBase <= wrData[DATA_W-1:IDX_W];
      if (strobes.loadCasc) cascOut <= wrData;
    end
  end

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_IN),
  localparam int PAD_W = DATA_W - 1 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IN-1:0] irr,
  input  logic [NUM_IN-1:0] isr,
  input  logic [NUM_IN-1:0] imr,
  input  logic              pendValid,
  input  logic [IDX_W-1:0]  pendIdx,
  output picStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData
);

  initState_t initState;
  initState_t initNext;
  logic       needCasc;
  logic       needMode;
  logic       readIsr;
  logic       pollArm;
  logic       cmdWr;
  logic       dataWr;
  logic       cmdRd;
  logic       isInitCmd;
  logic       isSelCmd;
  logic [DATA_W-1:0] pollWord;

  assign cmdWr     = wrEn && !addr;
  assign dataWr    = wrEn && addr;
  assign cmdRd     = rdEn && !addr;
  assign isInitCmd = wrData[4];
  assign isSelCmd  = !wrData[4] && wrData[3];

  assign pollWord = {pendValid, {PAD_W{1'b0}}, pendIdx};

  always_comb begin
    strobes          = '0;
    strobes.initClr  = cmdWr && isInitCmd;
    strobes.eoi      = cmdWr && !isInitCmd && !wrData[3] && (wrData[7:5] == 3'b001);
    strobes.pollAck  = cmdRd && pollArm && pendValid;
    strobes.loadMask = dataWr && (initState == ST_RUN);
    strobes.loadVec  = dataWr && (initState == ST_VEC);
    strobes.loadCasc = dataWr && (initState == ST_CASC);
  end

  always_comb begin
    initNext = initState;
    if (cmdWr && isInitCmd) begin
      initNext = ST_VEC;
    end else if (dataWr) begin
      unique case (initState)
        ST_VEC:  initNext = needCasc ? ST_CASC : (needMode ? ST_MODE : ST_RUN);
        ST_CASC: initNext = needMode ? ST_MODE : ST_RUN;
        ST_MODE: initNext = ST_RUN;
        default: initNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initState <= ST_RUN;
      needCasc  <= 1'b0;
      needMode  <= 1'b0;
      readIsr   <= 1'b0;
      pollArm   <= 1'b0;
    end else begin
      initState <= initNext;
      if (cmdWr && isInitCmd) begin
        needCasc <= !wrData[1];
        needMode <= wrData[0];
        readIsr  <= 1'b0;
        pollArm  <= 1'b0;
      end else if (cmdWr && isSelCmd) begin
        if (wrData[2]) pollArm <= 1'b1;
        if (wrData[1]) readIsr <= wrData[0];
      end else if (cmdRd) begin
        pollArm <= 1'b0;
      end
    end
  end

  always_comb begin
    if (addr) rdData = DATA_W'(imr);
    else if (pollArm) rdData = pollWord;
    else if (readIsr) rdData = DATA_W'(isr);
    else rdData = DATA_W'(irr);
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              intOut,
  output logic [DATA_W-1:0] vecOut,
  output logic [DATA_W-1:0] cascOut
);

  picStrobes_t       strobes;
  logic [NUM_IN-1:0] irr;
  logic [NUM_IN-1:0] isr;
  logic [NUM_IN-1:0] imr;
  logic              pendValid;
  logic [IDX_W-1:0]  pendIdx;

  pic_ctrl #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .irr      (irr),
    .isr      (isr),
    .imr      (imr),
    .pendValid(pendValid),
    .pendIdx  (pendIdx),
    .strobes  (strobes),
    .rdData   (rdData)
  );

  pic_datapath #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqIn    (irqIn),
    .wrData   (wrData),
    .strobes  (strobes),
    .irr      (irr),
    .isr      (isr),
    .imr      (imr),
    .pendValid(pendValid),
    .pendIdx  (pendIdx),
    .vecOut   (vecOut),
    .cascOut  (cascOut)
  );

  assign intOut = pendValid;

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intOut,
  input logic              wrEn,
  input logic              rdEn,
  input logic              addr,
  input logic [DATA_W-1:0] wrData,
  input logic [NUM_IN-1:0] irr,
  input logic [NUM_IN-1:0] isr,
  input logic [NUM_IN-1:0] imr
);

  logic pastValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((irr & ~imr) != '0)); // R10

  AST_FULL_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !intOut); // R3

  AST_ISR_SINGLE_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> ($countones(isr & ~$past(isr)) <= 1)); // R6

  AST_EDGE_BLOCKED_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    pastValid |-> ((irr & ~$past(irr) & $past(isr)) == '0)); // R11

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !addr && !rdEn && wrData == 8'h20 && isr != '0)
      |=> ($countones(isr) + 1 == $countones($past(isr)))); // R9

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !addr && wrData[4]) |=> (isr == '0 && irr == '0)); // R13

endmodule

bind prio_irq_ctrl pic_checker #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) i_pic_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .intOut(intOut),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .wrData(wrData),
  .irr   (irr),
  .isr   (isr),
  .imr   (imr)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqIn = 8'h00;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       intOut;
  logic [7:0] vecOut;
  logic [7:0] cascOut;

  int  checkCnt = 0;
  int  failCnt = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .irqIn  (irqIn),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .intOut (intOut),
    .vecOut (vecOut),
    .cascOut(cascOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk);
    irqIn = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic initSeq();
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 intOut", {7'b0, intOut}, 8'h00);
    rd(1'b1, v); check("R1 mask", v, 8'hFF);
    rd(1'b0, v); check("R1 request reg", v, 8'h00);
  endtask

  task automatic testInit();
    logic [7:0] v;
    initSeq();
    check("R14 cascade word", cascOut, 8'h04);
    rd(1'b1, v); check("R2 mask untouched by init", v, 8'hFF);
    check("R12 base with idle index", vecOut, 8'h27);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R3 mask readback", v, 8'h00);
  endtask

  task automatic testEdge();
    logic [7:0] v;
    setIrq(8'h08);
    rd(1'b0, v); check("R4 request latched", v, 8'h08);
    check("R10 int high", {7'b0, intOut}, 8'h01);
    check("R12 vector", vecOut, 8'h23);
    setIrq(8'h00);
    rd(1'b0, v); check("R4 request dropped", v, 8'h00);
    check("R4 int low", {7'b0, intOut}, 8'h00);
  endtask

  task automatic testMask();
    logic [7:0] v;
    wr(1'b1, 8'h08);
    setIrq(8'h08);
    check("R3 masked no int", {7'b0, intOut}, 8'h00);
    rd(1'b0, v); check("R3 masked still latched", v, 8'h08);
    wr(1'b1, 8'h00);
    check("R3 unmasked int", {7'b0, intOut}, 8'h01);
    setIrq(8'h00);
  endtask

  task automatic testPollPriority();
    logic [7:0] v;
    setIrq(8'h24);
    check("R12 vector winner", vecOut, 8'h22);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); check("R5 R6 poll result", v, 8'h82);
    rd(1'b0, v); check("R6 request cleared", v, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R8 in-service read", v, 8'h04);
    rd(1'b0, v); check("R8 selection persists", v, 8'h04);
    check("R10 lower blocked", {7'b0, intOut}, 8'h00);
    setIrq(8'h20);
    setIrq(8'h24);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); check("R11 edge ignored in service", v, 8'h20);
    wr(1'b0, 8'h20);
    check("R9 R10 int after eoi", {7'b0, intOut}, 8'h01);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R9 in-service empty", v, 8'h00);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); check("R6 poll input 5", v, 8'h85);
    setIrq(8'h26);
    check("R10 higher outranks service", {7'b0, intOut}, 8'h01);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); check("R5 poll input 1", v, 8'h81);
    rd(1'b0, v); check("R6 two in service", v, 8'h22);
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R9 clears top only", v, 8'h20);
    wr(1'b0, 8'h20);
    rd(1'b0, v); check("R9 second eoi", v, 8'h00);
  endtask

  task automatic testSpurious();
    logic [7:0] v;
    setIrq(8'h00);
    setIrq(8'h10);
    setIrq(8'h00);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); check("R7 empty poll", v, 8'h07);
    rd(1'b0, v); check("R7 in-service bit7 clear", v, 8'h00);
  endtask

  task automatic testReinit();
    logic [7:0] v;
    setIrq(8'h40);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); check("R6 poll input 6", v, 8'h86);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h0C);
    initSeq();
    rd(1'b0, v); check("R13 request selected, no poll", v, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R13 in-service cleared", v, 8'h00);
    rd(1'b1, v); check("R13 mask kept", v, 8'h01);
    check("R13 no int", {7'b0, intOut}, 8'h00);
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h55);
    rd(1'b1, v); check("R2 single mode skips cascade", v, 8'h55);
    check("R14 cascade kept", cascOut, 8'h04);
    check("R12 new base", vecOut, 8'h4F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testInit();
    testEdge();
    testMask();
    testPollPriority();
    testSpurious();
    testReinit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule